// File: doc/BRIEF.md
# Coherent Byte-Access Register Front End for an 8/16-bit Serial Port

This block sits between a byte-wide CPU bus and the shift engine of a serial peripheral. The peripheral moves either 8-bit or 16-bit words. A control bit selects the width. The block holds the data and match registers. Each register is split into a low byte and a high byte, so the CPU can reach each byte on its own while the engine always sees whole words.

When the CPU reads a 16-bit received word, the block freezes both bytes on the first access. The second access therefore returns the other half of the same word, even if a new word has arrived in between. Writes of 16-bit values are staged byte by byte. The whole word moves in a single cycle, either into the transmit queue or into the match register, only after both halves are present. The transmit queue holds up to eight words, or a single word when queueing is turned off. A push into a full queue is dropped and sets a sticky overflow flag. In master mode, flipping the width bit aborts the engine, empties the queue and clears the status.

Top module: `spi_reg_front`

## Requirements
- R1: After reset the width bit and the master bit are 0, the queue is empty (`tx_valid` low), `match_value` is 0, `core_abort` is low, and the status register reads 0x02.
- R2: In 8-bit mode (width bit 0), reads of address 1 (data high) and address 3 (match high) return 0, and writes to those addresses change neither the transmit queue nor `match_value`.
- R3: In 8-bit mode, a write to address 0 pushes `{8'h00, byte}` into the queue in that cycle. A write to address 2 sets `match_value` to `{8'h00, byte}`. A read of address 0 returns `rx_word[7:0]` directly.
- R4: In 16-bit mode, the first read of address 0 or 1 captures `rx_word`. Further reads of either address return bytes of the captured word until the other address has been read. The read after that release captures again.
- R5: In 16-bit mode, data bytes written to address 0 (low) and address 1 (high) are staged in either order. The word `{high, low}` is pushed in the cycle the second, different byte is written. Writing the same byte again replaces it and pushes nothing.
- R6: In 16-bit mode, match bytes written to address 2 (low) and address 3 (high) follow the same staging rule. `match_value` changes only in the cycle the second byte is written.
- R7: Reads of addresses 2 and 3 return the current `match_value` bytes; staged but uncommitted match bytes are not visible.
- R8: The queue delivers words in push order on `tx_data` while `tx_valid` is high. `tx_pop` removes the head and is ignored when the queue is empty. Capacity is FIFO_DEPTH words when `fifo_en` is 1, and 1 word when it is 0.
- R9: A push while the queue holds its capacity is dropped, even if `tx_pop` removes a word in the same cycle. The drop sets the sticky overflow bit (status bit 0).
- R10: A CTRL write that flips the width bit clears the read capture and all staged bytes. If the master bit was already 1 before that write, it also empties the queue, clears overflow and raises `core_abort` for exactly one cycle. A CTRL write that keeps the width bit does none of this.
- R11: Address 4 is CTRL (bit 0 width, bit 1 master; both read back). Address 5 is status: bit 0 overflow, bit 1 queue empty, bit 2 queue full. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, combinational from address |
| fifo_en | input | 1 | 1: queue capacity FIFO_DEPTH, 0: capacity 1 |
| rx_word | input | 16 | Latest word received by the shift engine |
| tx_valid | output | 1 | Queue head is valid |
| tx_data | output | 16 | Queue head word |
| tx_pop | input | 1 | Engine consumes the head word |
| match_value | output | 16 | Committed match word |
| core_abort | output | 1 | One-cycle abort and idle request to the engine |

## Verification
The CPU push and the engine pop can land in the same cycle. The bench provokes this with the queue full, where the push must still be dropped and flagged while the head is removed. It also provokes it with the queue empty, where the pop must be ignored and the pushed word must appear at the head. A behavioural queue model, stepped at every clock edge, judges both cases by comparing `tx_valid`, `tx_data` and the status byte on each cycle.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [2:0] ADR_DLO  = 3'd0;
    localparam logic [2:0] ADR_DHI  = 3'd1;
    localparam logic [2:0] ADR_MLO  = 3'd2;
    localparam logic [2:0] ADR_MHI  = 3'd3;
    localparam logic [2:0] ADR_CTRL = 3'd4;
    localparam logic [2:0] ADR_STAT = 3'd5;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } stage_byte_t;

    typedef struct packed {
        logic master;
        logic wide;
    } ctrl_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic ovf;
    } status_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input byte_sel_e sel);
        return (sel == BYTE_HI) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/spi_rd_latch.sv
module spi_rd_latch
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rd_en,
    input  byte_sel_e         sel,
    input  logic [WORD_W-1:0] live,
    output logic [WORD_W-1:0] view
);

    logic              held;
    byte_sel_e         first_sel;
    logic [WORD_W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held      <= 1'b0;
            first_sel <= BYTE_LO;
            cap       <= '0;
        end else if (rd_en) begin
            if (!held) begin
                cap       <= live;
                held      <= 1'b1;
                first_sel <= sel;
            end else if (sel != first_sel) begin
                held <= 1'b0;
            end
        end
    end

    always_comb view = held ? cap : live;

    AST_HELD_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ($past(held) && held) |-> (view == $past(view))) else $error("frozen word moved"); // R4

endmodule

// File: rtl/spi_wr_stage.sv
module spi_wr_stage
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  byte_sel_e         sel,
    input  logic [BYTE_W-1:0] din,
    output logic              commit,
    output logic [WORD_W-1:0] word,
    output logic              pending
);

    stage_byte_t lo_q;
    stage_byte_t hi_q;

    always_comb begin
        commit  = wr_en && ((sel == BYTE_HI) ? lo_q.valid : hi_q.valid);
        word    = (sel == BYTE_HI) ? {din, lo_q.data} : {hi_q.data, din};
        pending = lo_q.valid || hi_q.valid;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            if (commit) begin
                lo_q.valid <= 1'b0;
                hi_q.valid <= 1'b0;
            end else if (sel == BYTE_HI) begin
                hi_q <= '{valid: 1'b1, data: din};
            end else begin
                lo_q <= '{valid: 1'b1, data: din};
            end
        end
    end

    AST_ONE_HALF_STAGED: assert property (@(posedge clk) disable iff (rst)
        !(lo_q.valid && hi_q.valid)) else $error("both halves staged without commit"); // R5

    AST_COMMIT_NEEDS_PARTNER: assert property (@(posedge clk) disable iff (rst)
        commit |-> pending) else $error("commit with nothing staged"); // R5

endmodule

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo
    import spi_regif_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              single,
    input  logic              push,
    input  logic [WORD_W-1:0] din,
    input  logic              pop,
    output logic              valid,
    output logic [WORD_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_ptr;
    logic [CW-1:0]     count;
    logic [CW-1:0]     cap;
    logic              do_push;
    logic              do_pop;

    always_comb begin
        cap     = single ? CW'(1) : CAP_FULL;
        full    = (count >= cap);
        empty   = (count == '0);
        valid   = !empty;
        dout    = mem[rd_ptr];
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CAP_FULL) else $error("queue count beyond depth"); // R8

    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count))) else $error("dropped push stored"); // R9

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
    import spi_regif_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    input  logic        fifo_en,
    input  logic [15:0] rx_word,
    output logic        tx_valid,
    output logic [15:0] tx_data,
    input  logic        tx_pop,
    output logic [15:0] match_value,
    output logic        core_abort
);

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;
    logic              ovf_q;
    logic              abort_q;
    logic [WORD_W-1:0] match_q;

    logic wr_dlo, wr_dhi, wr_mlo, wr_mhi, wr_ctrl;
    logic rd_data;
    logic width_flip, flush;

    logic              d_commit, d_pending, m_commit, m_pending;
    logic [WORD_W-1:0] d_word, m_word;
    logic [WORD_W-1:0] rd_view;

    logic              push_req;
    logic [WORD_W-1:0] push_word;
    logic              q_full, q_empty, q_drop;
    status_t           stat;
    logic              unused_wbits;

    always_comb begin
        wr_dlo     = cpu_wr && (cpu_addr == ADR_DLO);
        wr_dhi     = cpu_wr && (cpu_addr == ADR_DHI);
        wr_mlo     = cpu_wr && (cpu_addr == ADR_MLO);
        wr_mhi     = cpu_wr && (cpu_addr == ADR_MHI);
        wr_ctrl    = cpu_wr && (cpu_addr == ADR_CTRL);
        rd_data    = cpu_rd && ctrl_q.wide &&
                     ((cpu_addr == ADR_DLO) || (cpu_addr == ADR_DHI));
        ctrl_new   = cpu_wdata[1:0];
        width_flip = wr_ctrl && (ctrl_new.wide != ctrl_q.wide);
        flush      = width_flip && ctrl_q.master;
        unused_wbits = ^cpu_wdata[7:2];
    end

    spi_rd_latch u_rd_latch (
        .clk   (clk),
        .rst   (rst),
        .clear (width_flip),
        .rd_en (rd_data),
        .sel   ((cpu_addr == ADR_DHI) ? BYTE_HI : BYTE_LO),
        .live  (rx_word),
        .view  (rd_view)
    );

    spi_wr_stage u_data_stage (
        .clk     (clk),
        .rst     (rst),
        .clear   (width_flip),
        .wr_en   (ctrl_q.wide && (wr_dlo || wr_dhi)),
        .sel     (wr_dhi ? BYTE_HI : BYTE_LO),
        .din     (cpu_wdata),
        .commit  (d_commit),
        .word    (d_word),
        .pending (d_pending)
    );

    spi_wr_stage u_match_stage (
        .clk     (clk),
        .rst     (rst),
        .clear   (width_flip),
        .wr_en   (ctrl_q.wide && (wr_mlo || wr_mhi)),
        .sel     (wr_mhi ? BYTE_HI : BYTE_LO),
        .din     (cpu_wdata),
        .commit  (m_commit),
        .word    (m_word),
        .pending (m_pending)
    );

    always_comb begin
        if (ctrl_q.wide) begin
            push_req  = d_commit;
            push_word = d_word;
        end else begin
            push_req  = wr_dlo;
            push_word = {{BYTE_W{1'b0}}, cpu_wdata};
        end
    end

    spi_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .single (!fifo_en),
        .push   (push_req),
        .din    (push_word),
        .pop    (tx_pop),
        .valid  (tx_valid),
        .dout   (tx_data),
        .full   (q_full),
        .empty  (q_empty),
        .drop   (q_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ovf_q   <= 1'b0;
            abort_q <= 1'b0;
            match_q <= '0;
        end else begin
            abort_q <= flush;
            if (wr_ctrl) ctrl_q <= ctrl_new;
            if (flush)       ovf_q <= 1'b0;
            else if (q_drop) ovf_q <= 1'b1;
            if (ctrl_q.wide && m_commit)  match_q <= m_word;
            else if (!ctrl_q.wide && wr_mlo) match_q <= {{BYTE_W{1'b0}}, cpu_wdata};
        end
    end

    always_comb begin
        stat = '{full: q_full, empty: q_empty, ovf: ovf_q};
        case (cpu_addr)
            ADR_DLO:  cpu_rdata = pick_byte(rd_view, BYTE_LO);
            ADR_DHI:  cpu_rdata = ctrl_q.wide ? pick_byte(rd_view, BYTE_HI) : '0;
            ADR_MLO:  cpu_rdata = pick_byte(match_q, BYTE_LO);
            ADR_MHI:  cpu_rdata = ctrl_q.wide ? pick_byte(match_q, BYTE_HI) : '0;
            ADR_CTRL: cpu_rdata = {6'b0, ctrl_q};
            ADR_STAT: cpu_rdata = {5'b0, stat};
            default:  cpu_rdata = '0;
        endcase
        match_value = match_q;
        core_abort  = abort_q;
    end

    AST_NARROW_NOTHING_STAGED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.wide |-> (!d_pending && !m_pending)) else $error("stage survived width switch"); // R10

    AST_ABORT_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
        core_abort |-> (ctrl_q.wide != $past(ctrl_q.wide))) else $error("abort without width flip"); // R10

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(q_drop)) else $error("overflow without drop"); // R9

endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        fifo_en = 1'b1;
    logic [15:0] rx_word = '0;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_pop = 1'b0;
    logic [15:0] match_value;
    logic        core_abort;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // behavioural reference state
    int   q[$];
    bit   m_wide, m_master, m_ovf, m_abort;
    int   m_match;
    bit   m_held; int m_cap; int m_first;
    bit   d_lv, d_hv, mt_lv, mt_hv;
    int   d_lb, d_hb, mt_lb, mt_hb;

    spi_reg_front #(.FIFO_DEPTH(8)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fifo_en(fifo_en), .rx_word(rx_word),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .match_value(match_value), .core_abort(core_abort)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=0x%0h exp=0x%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int cap_now();
        return fifo_en ? 8 : 1;
    endfunction

    function automatic int exp_rdata(input int a);
        int v;
        case (a)
            0: v = m_held ? (m_cap & 8'hff) : (rx_word & 8'hff);
            1: v = m_wide ? (m_held ? (m_cap >> 8) : (rx_word >> 8)) : 0;
            2: v = m_match & 8'hff;
            3: v = m_wide ? (m_match >> 8) : 0;
            4: v = {m_master, m_wide};
            5: v = {(q.size() >= cap_now()), (q.size() == 0), m_ovf};
            default: v = 0;
        endcase
        return v & 8'hff;
    endfunction

    task automatic model_update(input int a, input bit w, input bit r, input int d, input bit p);
        bit full_b = (q.size() >= cap_now());
        bit popped = p && (q.size() > 0);
        bit pushb = 0;
        int pw = 0;
        m_abort = 0;
        if (w) begin
            case (a)
                0: if (!m_wide) begin pushb = 1; pw = d; end
                   else if (d_hv) begin pushb = 1; pw = (d_hb << 8) | d; d_hv = 0; end
                   else begin d_lb = d; d_lv = 1; end
                1: if (m_wide) begin
                       if (d_lv) begin pushb = 1; pw = (d << 8) | d_lb; d_lv = 0; end
                       else begin d_hb = d; d_hv = 1; end
                   end
                2: if (!m_wide) m_match = d;
                   else if (mt_hv) begin m_match = (mt_hb << 8) | d; mt_hv = 0; end
                   else begin mt_lb = d; mt_lv = 1; end
                3: if (m_wide) begin
                       if (mt_lv) begin m_match = (d << 8) | mt_lb; mt_lv = 0; end
                       else begin mt_hb = d; mt_hv = 1; end
                   end
                4: begin
                       if (d[0] != m_wide) begin
                           m_held = 0; d_lv = 0; d_hv = 0; mt_lv = 0; mt_hv = 0;
                           if (m_master) begin q.delete(); m_ovf = 0; m_abort = 1; popped = 0; end
                       end
                       m_wide = d[0]; m_master = d[1];
                   end
                default: ;
            endcase
        end
        if (r && m_wide && (a <= 1)) begin
            if (!m_held) begin m_cap = rx_word; m_held = 1; m_first = a; end
            else if (a != m_first) m_held = 0;
        end
        if (popped) void'(q.pop_front());
        if (pushb) begin
            if (full_b) m_ovf = 1; else q.push_back(pw);
        end
    endtask

    task automatic step(input int a, input bit w, input bit r, input int d, input bit p,
                        input string tag);
        cpu_addr = 3'(a); cpu_wr = w; cpu_rd = r; cpu_wdata = 8'(d); tx_pop = p;
        #1;
        if (r) check(tag, cpu_rdata, exp_rdata(a));
        @(posedge clk);
        model_update(a, w, r, d, p);
        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0; tx_pop = 0;
        check("R8 tx_valid", tx_valid, q.size() != 0);
        if (q.size() != 0) check("R8 tx_data order", tx_data, q[0]);
        check("R6 match_value", match_value, m_match);
        check("R10 core_abort", core_abort, m_abort);
    endtask

    task automatic wr(input int a, input int d, input string tag); step(a, 1, 0, d, 0, tag); endtask
    task automatic rd(input int a, input string tag);              step(a, 0, 1, 0, 0, tag); endtask
    task automatic pop1(input string tag);                         step(7, 0, 0, 0, 1, tag); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_valid", tx_valid, 0);
        check("R1 match", match_value, 0);
        check("R1 abort", core_abort, 0);
        rd(5, "R1 status");
        rd(4, "R1 ctrl");
        rd(6, "R11 unused addr");
        // R2 / R3 narrow mode
        rx_word = 16'hA55A;
        wr(1, 8'hAA, "R2 dhi write ignored");
        rd(1, "R2 dhi reads zero");
        wr(3, 8'hBB, "R2 mhi write ignored");
        rd(3, "R2 mhi reads zero");
        rd(0, "R3 dlo direct");
        wr(0, 8'h5C, "R3 narrow push");
        wr(2, 8'h33, "R3 narrow match");
        rd(2, "R7 mlo");
        pop1("R8 pop");
        pop1("R8 pop on empty ignored");
        // switch to wide, slave
        wr(4, 8'h01, "R10 width flip slave");
        rd(4, "R11 ctrl readback");
        // R4 read coherency
        rx_word = 16'h1234;
        rd(1, "R4 first read hi");
        rx_word = 16'hABCD;
        rd(1, "R4 repeat hi frozen");
        rd(0, "R4 other byte releases");
        rd(0, "R4 recapture lo");
        rx_word = 16'h5555;
        rd(1, "R4 other hi from capture");
        // R5 data staging
        wr(0, 8'h11, "R5 stage lo");
        wr(0, 8'h22, "R5 overwrite lo");
        wr(1, 8'h99, "R5 commit hi after lo");
        wr(1, 8'h01, "R5 stage hi");
        wr(0, 8'h02, "R5 commit lo after hi");
        // R6 / R7 match staging
        wr(3, 8'h77, "R6 stage mhi");
        rd(3, "R7 staged not visible");
        wr(2, 8'h88, "R6 commit match");
        rd(3, "R7 mhi after commit");
        // R8 / R9 fill queue
        for (int i = 0; i < 7; i++) begin
            wr(0, i, "R8 fill lo");
            wr(1, 8'hC0 + i, "R8 fill hi");
        end
        rd(5, "R11 full status");
        wr(0, 8'hEE, "R9 stage extra");
        wr(1, 8'hEF, "R9 push on full dropped");
        rd(5, "R9 overflow sticky");
        // push and pop together while full: push dropped
        wr(0, 8'h44, "R9 stage");
        step(1, 1, 0, 8'h45, 1, "R9 push+pop when full");
        for (int i = 0; i < 8; i++) pop1("R8 drain");
        rd(5, "R9 overflow stays after drain");
        // push and pop together while empty: push stored
        wr(0, 8'h10, "R8 stage");
        step(1, 1, 0, 8'h20, 1, "R8 push+pop when empty");
        pop1("R8 drain one");
        // capacity 1
        fifo_en = 0;
        wr(0, 1, "R8 single a"); wr(1, 2, "R8 single b");
        wr(0, 3, "R8 single c"); wr(1, 4, "R8 single drop");
        rd(5, "R8 single full");
        pop1("R8 single drain");
        fifo_en = 1;
        // R10 master switch
        wr(4, 8'h03, "R10 same width no abort");
        wr(0, 8'h61, "R10 fill"); wr(1, 8'h62, "R10 fill");
        wr(1, 8'h44, "R10 stage hi before flip");
        wr(3, 8'h55, "R10 stage mhi before flip");
        rx_word = 16'h9876;
        rd(1, "R10 capture before flip");
        wr(4, 8'h02, "R10 flip to narrow master");
        rd(5, "R10 status cleared");
        rd(1, "R2 dhi zero after flip");
        wr(4, 8'h03, "R10 flip back wide");
        rx_word = 16'h2468;
        rd(0, "R10 capture cleared");
        rd(1, "R10 release");
        wr(0, 8'h55, "R10 stage cleared no push");
        wr(1, 8'h66, "R10 commit after flip");
        wr(2, 8'h99, "R10 match stage cleared");
        rd(2, "R7 match unchanged");
        pop1("R8 final drain");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule